// File: doc/BRIEF.md
# Serial Host Register Port

This block is a four-wire serial slave. A host selects it with an active-low chip select and, on the serial clock, shifts in a 7-bit register address, a read/write flag and one data byte. A write commits the byte to the addressed register once the last data bit arrives. A read returns the addressed byte on the serial output during the eight data slots.

The serial clock, chip select and serial input arrive asynchronously. They pass through a synchroniser into the system clock domain, and edge detection runs there. The output enable is low whenever the block is not actively returning read data, so the pad ring can tri-state the shared line and other slaves can use the same wires.

Behind the port sit a small block of scratch registers, a register that drives eight general-purpose output pins, a register that reflects eight general-purpose input pins, and two read-only status bytes. A window of addresses is held back for test. Those addresses, and every address that is not mapped, are treated as invalid.

Top module: `host_serial_regs`

## Requirements
- R1: A frame is 16 serial bits. Bits 0–6 are address bits A0..A6 (least significant first), bit 7 is the direction flag (0 = write, 1 = read), and bits 8–15 are data bits D0..D7 (least significant first).
- R2: `sdi` is taken on a rising `sck` edge. `sdo` only changes after a falling `sck` edge.
- R3: `sdo_oe` is high only while `cs_n` is low, the frame is a read of a readable address, and the data slots are in progress. It drops after the falling edge that follows D7, and when `cs_n` goes high.
- R4: A write takes effect only on the rising edge of D7. If `cs_n` goes high before that edge, the frame is discarded and no register changes.
- R5: A synchronous active-high `rst` clears every register. After reset, `gpo` is 0, every readable register that holds state reads 0, and `sdo_oe` is low.
- R6: Addresses 0x0C–0x0F are reserved for test and addresses 0x10–0x7F are unmapped. Both kinds are invalid: a read of one leaves `sdo_oe` low, and a write to one changes no register.
- R7: Address 0x08 holds the output-port byte. It drives `gpo` directly and reads back the value written.
- R8: Address 0x09 returns the `gpi` pins, as sampled when the direction bit is taken. Writes to it are ignored.
- R9: Addresses 0x0A and 0x0B return `stat_in[7:0]` and `stat_in[15:8]`. Writes to them are ignored.
- R10: Addresses 0x00–0x07 are read/write scratch bytes that keep the last value written.
- R11: Clock edges after the 16th bit of a frame are ignored. A new frame starts only after `cs_n` has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high clear |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| gpi | input | 8 | General-purpose input pins |
| stat_in | input | 16 | Two read-only status bytes |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| gpo | output | 8 | General-purpose output pins |

## Verification
The assertions check the following on every cycle:
- the output enable falls after chip select is released;
- the enable never rises for an invalid address;
- `sdo` moves only after a falling clock edge;
- the output-port byte holds still unless a write commits;
- the bit counter never passes the frame length;
- reset clears the output register.

Some behaviour depends on the data carried in whole frames, and only the bench scenarios can show it:
- the LSB-first order of address and data;
- the discard of aborted frames;
- the ignored extra bits after bit 16;
- read-only protection of the input and status bytes;
- isolation of the reserved window from the scratch bytes.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;
    localparam int RW_SLOT    = ADDR_W;
    localparam int DATA_FIRST = ADDR_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam int NSCR      = 8;
    localparam int SCR_BASE  = 0;
    localparam int GPO_ADDR  = 8;
    localparam int GPI_ADDR  = 9;
    localparam int STAT_BASE = 10;
    localparam int NSTAT     = 2;
    localparam int RSV_BASE  = 12;
    localparam int RSV_N     = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        RG_NONE, RG_SCR, RG_GPO, RG_GPI, RG_STAT, RG_RSV
    } region_e;

    typedef struct packed {
        addr_t addr;
        logic  rw;
        logic  valid;
        byte_t wbuf;
        byte_t rsh;
    } frame_t;

    function automatic region_e region_of(addr_t a);
        int v;
        v = int'(a);
        if (v >= SCR_BASE && v < SCR_BASE + NSCR)     return RG_SCR;
        if (v == GPO_ADDR)                            return RG_GPO;
        if (v == GPI_ADDR)                            return RG_GPI;
        if (v >= STAT_BASE && v < STAT_BASE + NSTAT)  return RG_STAT;
        if (v >= RSV_BASE && v < RSV_BASE + RSV_N)    return RG_RSV;
        return RG_NONE;
    endfunction

    function automatic logic is_readable(region_e r);
        return (r == RG_SCR) || (r == RG_GPO) || (r == RG_GPI) || (r == RG_STAT);
    endfunction

    function automatic logic is_writable(region_e r);
        return (r == RG_SCR) || (r == RG_GPO);
    endfunction
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stg[s] <= RST_VAL;
                else if (s == 0) stg[s] <= d;
                else             stg[s] <= stg[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hostif_frame.sv
module hostif_frame
    import hostif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n_s,
    input  logic  sck_s,
    input  logic  sdi_s,
    input  byte_t rd_data,
    input  logic  rd_valid,
    output addr_t addr,
    output logic  wr_en,
    output byte_t wr_data,
    output logic  sdo,
    output logic  sdo_oe
);
    logic             sck_d;
    logic             rise, fall, cs_act;
    logic [CNT_W-1:0] cnt;
    frame_t           fr;

    assign cs_act = !cs_n_s;
    assign rise   = cs_act && sck_s && !sck_d;
    assign fall   = cs_act && !sck_s && sck_d;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            cnt    <= '0;
            fr.rw  <= 1'b0;
            fr.valid <= 1'b0;
            sdo_oe <= 1'b0;
            if (rst) begin
                fr.addr <= '0;
                fr.wbuf <= '0;
                fr.rsh  <= '0;
                sdo     <= 1'b0;
            end
        end else begin
            if (rise && cnt < CNT_W'(FRAME_BITS)) begin
                cnt <= cnt + 1'b1;
                if (cnt < CNT_W'(RW_SLOT)) begin
                    fr.addr <= {sdi_s, fr.addr[ADDR_W-1:1]};
                end else if (cnt == CNT_W'(RW_SLOT)) begin
                    fr.rw    <= sdi_s;
                    fr.valid <= rd_valid;
                    fr.rsh   <= rd_data;
                end else begin
                    fr.wbuf <= {sdi_s, fr.wbuf[DATA_W-1:1]};
                end
            end
            if (fall) begin
                if (fr.rw && fr.valid && cnt >= CNT_W'(DATA_FIRST) && cnt < CNT_W'(FRAME_BITS)) begin
                    sdo_oe <= 1'b1;
                    sdo    <= fr.rsh[0];
                    fr.rsh <= fr.rsh >> 1;
                end else begin
                    sdo_oe <= 1'b0;
                end
            end
        end
    end

    assign addr    = fr.addr;
    assign wr_en   = rise && !fr.rw && cnt == CNT_W'(FRAME_BITS - 1);
    assign wr_data = {sdi_s, fr.wbuf[DATA_W-1:1]};

    // R3: releasing chip select silences the output on the next cycle
    p_oe_release_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !sdo_oe);
    // R2: serial output moves only after a falling serial clock edge
    p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (sdo != $past(sdo)) |-> $past(fall));
    // R11: counter stops at the frame length
    p_cnt_limit_r11: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_BITS));
endmodule

// File: rtl/hostif_regfile.sv
module hostif_regfile
    import hostif_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  addr_t                 addr,
    input  logic                  wr_en,
    input  byte_t                 wr_data,
    input  byte_t                 gpi,
    input  logic [NSTAT*DATA_W-1:0] stat_in,
    output byte_t                 rd_data,
    output logic                  rd_valid,
    output byte_t                 gpo
);
    localparam int SCR_IW = $clog2(NSCR);

    byte_t   scr [NSCR];
    byte_t   gpo_q;
    byte_t   stat_b [NSTAT];
    region_e reg_sel;

    assign reg_sel = region_of(addr);

    generate
        for (genvar k = 0; k < NSTAT; k++) begin : g_stat
            assign stat_b[k] = stat_in[k*DATA_W +: DATA_W];
        end
        for (genvar k = 0; k < NSCR; k++) begin : g_scr
            always_ff @(posedge clk) begin
                if (rst) scr[k] <= '0;
                else if (wr_en && reg_sel == RG_SCR && addr[SCR_IW-1:0] == SCR_IW'(k))
                    scr[k] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                              gpo_q <= '0;
        else if (wr_en && reg_sel == RG_GPO)  gpo_q <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel)
            RG_SCR:  rd_data = scr[addr[SCR_IW-1:0]];
            RG_GPO:  rd_data = gpo_q;
            RG_GPI:  rd_data = gpi;
            RG_STAT: begin
                for (int k = 0; k < NSTAT; k++)
                    if (addr == ADDR_W'(STAT_BASE + k)) rd_data = stat_b[k];
            end
            default: rd_data = '0;
        endcase
    end

    assign rd_valid = is_readable(reg_sel);
    assign gpo      = gpo_q;

    // R4: the output byte holds unless a write commits
    p_gpo_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(gpo_q));
    // R5: reset clears the output byte
    p_reset_gpo_r5: assert property (@(posedge clk)
        rst |=> gpo_q == '0);
endmodule

// File: rtl/host_serial_regs.sv
module host_serial_regs
    import hostif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        sdi,
    input  logic [7:0]  gpi,
    input  logic [15:0] stat_in,
    output logic        sdo,
    output logic        sdo_oe,
    output logic [7:0]  gpo
);
    logic [2:0] pins_s;
    addr_t      addr;
    logic       wr_en, rd_valid;
    byte_t      wr_data, rd_data;

    hostif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk), .rst (rst),
        .d   ({cs_n, sck, sdi}),
        .q   (pins_s)
    );

    hostif_frame u_frame (
        .clk      (clk),       .rst     (rst),
        .cs_n_s   (pins_s[2]), .sck_s   (pins_s[1]), .sdi_s (pins_s[0]),
        .rd_data  (rd_data),   .rd_valid(rd_valid),
        .addr     (addr),      .wr_en   (wr_en),     .wr_data(wr_data),
        .sdo      (sdo),       .sdo_oe  (sdo_oe)
    );

    hostif_regfile u_regs (
        .clk     (clk),     .rst     (rst),
        .addr    (addr),    .wr_en   (wr_en),   .wr_data (wr_data),
        .gpi     (gpi),     .stat_in (stat_in),
        .rd_data (rd_data), .rd_valid(rd_valid), .gpo    (gpo)
    );

    // R6: output enable only for a readable address
    p_oe_valid_r6: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> rd_valid);
    // R5: output enable low after reset
    p_reset_oe_r5: assert property (@(posedge clk)
        rst |=> !sdo_oe);
endmodule

// File: tb/host_serial_regs_test.sv
module host_serial_regs_test;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [7:0]  gpi = 8'h00;
    logic [15:0] stat_in = 16'h0000;
    logic        sdo, sdo_oe;
    logic [7:0]  gpo;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    host_serial_regs uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .gpi(gpi), .stat_in(stat_in), .sdo(sdo), .sdo_oe(sdo_oe), .gpo(gpo)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One frame; ndata data bits; extra bits beyond 8 carry inverted data
    task automatic xfer(input logic [6:0] a, input bit rw, input logic [7:0] wd,
                        input int ndata, input bit keep_cs,
                        output logic [7:0] rd, output int oe_data, output bit oe_early,
                        output bit oe_after);
        rd = '0; oe_data = 0; oe_early = 0;
        cs_n = 1'b0; sck = 1'b0;
        waitc(HP);
        for (int i = 0; i < 8 + ndata; i++) begin
            if (i < 7)       sdi = a[i];
            else if (i == 7) sdi = rw;
            else if (i < 16) sdi = wd[i-8];
            else             sdi = ~wd[(i-16) & 7];
            waitc(HP);
            if (i < 8 && sdo_oe) oe_early = 1;
            if (i >= 8 && i < 16) begin
                rd[i-8] = sdo;
                if (sdo_oe) oe_data++;
            end
            sck = 1'b1;
            waitc(HP);
            sck = 1'b0;
        end
        waitc(HP);
        oe_after = sdo_oe;
        if (!keep_cs) begin
            cs_n = 1'b1;
            waitc(HP);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r; int o; bit e, f;
        xfer(a, 1'b0, d, 8, 1'b0, r, o, e, f);
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic [7:0] r; int o; bit e, f;
        xfer(a, 1'b1, 8'h00, 8, 1'b0, r, o, e, f);
        chk(r == exp && o == 8, req, {8'h0, r}, {8'h0, exp});
        chk(!e && !f, {req, " R3 enable window"}, {15'h0, e | f}, 16'h0);
    endtask

    task automatic t_reset;
        chk(gpo == 8'h00, "R5 gpo after reset", {8'h0, gpo}, 16'h0);
        chk(!sdo_oe, "R5 enable after reset", {15'h0, sdo_oe}, 16'h0);
        rd_chk(7'h03, 8'h00, "R5 scratch after reset");
    endtask

    task automatic t_scratch;
        wr(7'h03, 8'hA5);
        wr(7'h00, 8'h01);
        wr(7'h07, 8'h80);
        rd_chk(7'h03, 8'hA5, "R10 scratch 3");
        rd_chk(7'h00, 8'h01, "R1 lsb order scratch 0");
        rd_chk(7'h07, 8'h80, "R1 msb order scratch 7");
    endtask

    task automatic t_gpo;
        wr(7'h08, 8'h3C);
        chk(gpo == 8'h3C, "R7 gpo pins", {8'h0, gpo}, 16'h3C);
        rd_chk(7'h08, 8'h3C, "R7 gpo readback");
    endtask

    task automatic t_gpi;
        gpi = 8'h96;
        rd_chk(7'h09, 8'h96, "R8 gpi read");
        wr(7'h09, 8'h00);
        chk(gpo == 8'h3C, "R8 gpi write leaves gpo", {8'h0, gpo}, 16'h3C);
        rd_chk(7'h09, 8'h96, "R8 gpi after write");
    endtask

    task automatic t_status;
        stat_in = 16'hC37E;
        rd_chk(7'h0A, 8'h7E, "R9 status low byte");
        rd_chk(7'h0B, 8'hC3, "R9 status high byte");
        wr(7'h0A, 8'h11);
        rd_chk(7'h0A, 8'h7E, "R9 status write ignored");
        rd_chk(7'h02, 8'h00, "R9 status write no alias");
    endtask

    task automatic t_invalid;
        logic [7:0] r; int o; bit e, f;
        wr(7'h04, 8'h5A);
        wr(7'h0C, 8'hFF);
        xfer(7'h0C, 1'b1, 8'h00, 8, 1'b0, r, o, e, f);
        chk(o == 0 && !f, "R6 reserved read stays off", 16'(o), 16'h0);
        rd_chk(7'h04, 8'h5A, "R6 reserved write no alias");
        xfer(7'h40, 1'b1, 8'h00, 8, 1'b0, r, o, e, f);
        chk(o == 0, "R6 unmapped read stays off", 16'(o), 16'h0);
        wr(7'h48, 8'h77);
        chk(gpo == 8'h3C, "R6 unmapped write no effect", {8'h0, gpo}, 16'h3C);
    endtask

    task automatic t_abort;
        logic [7:0] r; int o; bit e, f;
        xfer(7'h08, 1'b0, 8'hE1, 7, 1'b1, r, o, e, f);
        chk(gpo == 8'h3C, "R4 no commit before last bit", {8'h0, gpo}, 16'h3C);
        cs_n = 1'b1;
        waitc(HP);
        chk(gpo == 8'h3C, "R4 aborted frame discarded", {8'h0, gpo}, 16'h3C);
        xfer(7'h08, 1'b1, 8'h00, 4, 1'b1, r, o, e, f);
        chk(sdo_oe == 1'b1, "R3 enable mid read", {15'h0, sdo_oe}, 16'h1);
        cs_n = 1'b1;
        waitc(HP);
        chk(!sdo_oe, "R3 enable drops with cs", {15'h0, sdo_oe}, 16'h0);
    endtask

    task automatic t_overrun;
        logic [7:0] r; int o; bit e, f;
        xfer(7'h05, 1'b0, 8'h6B, 12, 1'b0, r, o, e, f);
        rd_chk(7'h05, 8'h6B, "R11 extra bits ignored");
        xfer(7'h05, 1'b1, 8'h00, 12, 1'b0, r, o, e, f);
        chk(r == 8'h6B && o == 8 && !f, "R2 R11 long read", {8'h0, r}, 16'h6B);
    endtask

    task automatic t_midreset;
        rst = 1'b1;
        waitc(4);
        rst = 1'b0;
        waitc(4);
        chk(gpo == 8'h00, "R5 gpo after second reset", {8'h0, gpo}, 16'h0);
        rd_chk(7'h03, 8'h00, "R5 scratch cleared");
    endtask

    bit done = 0;

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(5);
        t_reset();
        t_scratch();
        t_gpo();
        t_gpi();
        t_status();
        t_invalid();
        t_abort();
        t_overrun();
        t_midreset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule